// File: doc/BRIEF.md
# Maskable Interrupt Aggregator

This block gathers single-cycle event pulses from four categories of status sources into four pending-interrupt registers. Each category has its own enable register holding one bit per pending bit. When an enabled event arrives, its pending bit sets and the block pulls its shared interrupt request low. When nothing is pending it releases the line to high impedance instead of driving it high.

A host reaches the registers through a small bus with separate write and read strobes. A read of a pending register returns its contents and clears it. A control register holds an acknowledge bit and a suspend bit. Writing the acknowledge bit with a value different from the stored one clears every pending register at once. Suspend holds the request off without touching the enable registers. A separate active-low clear input wipes all pending bits. After reset every category is fully masked.

Top module: `irq_aggregator`

## Requirements
- R1: After reset all pending registers, all enable registers and both control bits read 0, `irq_oe_o` is 0 and `irq_n_o` is 1.
- R2: Event bit b of category c is a level sampled on each clock. If enable bit b of category c is 1, pending bit b sets at that edge. From that edge on, `irq_oe_o` is 1 and `irq_n_o` is 0 unless suspend is set.
- R3: An event whose enable bit is 0 is not stored. Setting the enable bit afterwards raises no pending bit and no request.
- R4: A read strobe at a pending-register address returns its current contents on `bus_rdata` in the same cycle and clears that register at the clock edge. The other registers keep their contents.
- R5: An enabled event in the same cycle as a clearing read (or an acknowledge toggle) is kept, and its bit reads 1 afterwards.
- R6: While all pending registers are 0, `irq_oe_o` is 0 and `irq_n_o` is 1.
- R7: A write to the control register whose bit 0 differs from the stored acknowledge bit clears all four pending registers.
- R8: While suspend (control bit 1) is 1, the enable registers keep their values, enabled events still set pending bits, and `irq_oe_o` stays 0. Once suspend returns to 0, the request asserts if any bit is still pending.
- R9: While `clr_n_i` is 0, all pending registers are cleared at each edge and no event is stored.
- R10: Address map: 0 to 3 are the pending registers of categories 0 to 3, 4 to 7 are their enable registers (1 = enabled), 8 is the control register (bit 0 acknowledge, bit 1 suspend), and every other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 32 | Event levels; category c occupies bits [8c+7:8c] |
| clr_n_i | input | 1 | Active-low clear of all pending bits |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears pending registers) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the address |
| irq_n_o | output | 1 | Request level, 0 while asserted |
| irq_oe_o | output | 1 | Output enable for the request pad; 1 drives the line |

## Verification
The hardest case to reach from the ports is an enabled event landing in exactly the cycle in which a read strobe clears the same register. Without care, the new bit is lost or the returned value already contains it. The bench first sets one bit and then, on a single falling edge, raises the read strobe and a second event bit together. It checks that the read returns only the first bit and that a later read returns only the second. Suspend gets similar treatment: an event is latched while the request is held off, and the request is observed only after suspend is released.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int W    = 8,
  parameter int NCAT = 4,
  parameter int AW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCAT*W-1:0] evt_i,
  input  logic              clr_n_i,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq_n_o,
  output logic              irq_oe_o
);

  localparam int CTRL_ADDR = 2 * NCAT;

  logic [W-1:0]      pend_q [NCAT];
  logic [W-1:0]      en_q   [NCAT];
  logic [NCAT*W-1:0] pend_flat, en_flat;
  logic              ack_q, susp_q;

  wire ctrl_wr   = bus_wr && (bus_addr == AW'(CTRL_ADDR));
  wire ack_flip  = ctrl_wr && (bus_wdata[0] != ack_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_q  <= 1'b0;
      susp_q <= 1'b0;
    end else if (ctrl_wr) begin
      ack_q  <= bus_wdata[0];
      susp_q <= bus_wdata[1];
    end

  for (genvar g = 0; g < NCAT; g++) begin : g_cat
    wire rd_hit = bus_rd && (bus_addr == AW'(g));
    wire wipe   = rd_hit || ack_flip;
    wire [W-1:0] hit = evt_i[g*W +: W] & en_q[g];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)           pend_q[g] <= '0;
      else if (!clr_n_i)    pend_q[g] <= '0;
      else                  pend_q[g] <= (wipe ? '0 : pend_q[g]) | hit;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                      en_q[g] <= '0;
      else if (bus_wr && bus_addr == AW'(NCAT + g))    en_q[g] <= bus_wdata;

    assign pend_flat[g*W +: W] = pend_q[g];
    assign en_flat[g*W +: W]   = en_q[g];

    p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_hit && hit == '0) |=> pend_q[g] == '0);
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(bus_addr) < NCAT)
      bus_rdata = pend_q[bus_addr[$clog2(NCAT)-1:0]];
    else if (int'(bus_addr) < CTRL_ADDR)
      bus_rdata = en_q[bus_addr[$clog2(NCAT)-1:0]];
    else if (int'(bus_addr) == CTRL_ADDR)
      bus_rdata = W'({susp_q, ack_q});
  end

  assign irq_oe_o = (|pend_flat) && !susp_q;
  assign irq_n_o  = !irq_oe_o;

  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n_i && |(evt_i & en_flat)) |=> |pend_flat);

  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_flat == '0 && (evt_i & en_flat) == '0) |=> pend_flat == '0);

  p_suspend_masks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> $stable(en_flat));

  p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> !irq_oe_o);

  p_hard_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n_i |=> pend_flat == '0);

endmodule

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb_top;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, clr_n = 1, wr = 0, rd = 0;
  logic [31:0] evt = '0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic irq_n, irq_oe;
  int checks = 0, fails = 0;
  bit done = 0;
  bit ack_st = 0;

  always #2 clk = ~clk;

  irq_aggregator dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_n_i(clr_n),
    .bus_addr(addr), .bus_wr(wr), .bus_rd(rd), .bus_wdata(wdata),
    .bus_rdata(rdata), .irq_n_o(irq_n), .irq_oe_o(irq_oe));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic pulse(int cat, logic [7:0] b);
    @(negedge clk); evt[cat*W +: W] = b;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int i = 0; i < 9; i++) begin rd_reg(4'(i), d); check("R1 reg", d, 0); end
    rd_reg(4'd12, d); check("R10 unused", d, 0);
    check("R1 oe", irq_oe, 0); check("R1 irq_n", irq_n, 1);
  endtask

  task automatic t_latch;
    logic [7:0] d;
    wr_reg(4, 8'h0F);
    rd_reg(4, d); check("R10 enable readback", d, 8'h0F);
    pulse(0, 8'h33);
    check("R2 oe", irq_oe, 1); check("R2 irq_n", irq_n, 0);
    rd_reg(0, d); check("R4 read value", d, 8'h03);
    check("R6 oe released", irq_oe, 0); check("R6 irq_n", irq_n, 1);
    rd_reg(0, d); check("R4 cleared", d, 0);
  endtask

  task automatic t_masked;
    logic [7:0] d;
    pulse(1, 8'hF0);
    check("R3 no irq", irq_oe, 0);
    wr_reg(5, 8'hFF);
    check("R3 no late irq", irq_oe, 0);
    rd_reg(1, d); check("R3 not stored", d, 0);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    wr_reg(6, 8'hFF);
    pulse(2, 8'h01);
    @(negedge clk); addr = 2; rd = 1; evt[2*W +: W] = 8'h02; #1 d = rdata;
    @(negedge clk); rd = 0; evt = '0;
    check("R5 read value", d, 8'h01);
    check("R5 oe", irq_oe, 1);
    rd_reg(2, d); check("R5 kept", d, 8'h02);
  endtask

  task automatic t_ack;
    logic [7:0] d;
    wr_reg(7, 8'hFF);
    pulse(0, 8'h01); pulse(3, 8'h80); pulse(2, 8'h10);
    check("R7 pre oe", irq_oe, 1);
    ack_st = !ack_st;
    wr_reg(8, {7'd0, ack_st});
    check("R7 oe", irq_oe, 0);
    for (int i = 0; i < 4; i++) begin rd_reg(4'(i), d); check("R7 cleared", d, 0); end
    pulse(3, 8'h04);
    wr_reg(8, {7'd0, ack_st});
    check("R7 same value no clear", irq_oe, 1);
    rd_reg(3, d); check("R7 kept", d, 8'h04);
  endtask

  task automatic t_suspend;
    logic [7:0] d;
    wr_reg(8, {6'd0, 1'b1, ack_st});
    pulse(3, 8'h20);
    check("R8 held off", irq_oe, 0); check("R8 irq_n", irq_n, 1);
    rd_reg(7, d); check("R8 enable kept", d, 8'hFF);
    rd_reg(8, d); check("R8 ctrl readback", d, {6'd0, 1'b1, ack_st});
    wr_reg(8, {7'd0, ack_st});
    check("R8 released", irq_oe, 1);
    rd_reg(3, d); check("R8 latched", d, 8'h20);
  endtask

  task automatic t_hardclr;
    logic [7:0] d;
    pulse(0, 8'h02);
    @(negedge clk); clr_n = 0;
    @(negedge clk); evt[7:0] = 8'h04;
    @(negedge clk); evt = '0; clr_n = 1;
    check("R9 oe", irq_oe, 0);
    rd_reg(0, d); check("R9 cleared", d, 0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_latch; t_masked; t_same_cycle; t_ack; t_suspend; t_hardclr;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule